// File: doc/BRIEF.md
# TDM Network-Mode Serial Transmitter

This block sends data words on a time-division-multiplexed serial line. A frame begins on a bit-clock edge where the frame sync input is high. The frame is split into a programmable number of time slots, and each slot is one data word long. A 32-bit mask chooses which slots this transmitter owns. At the start of each owned slot, the word that the host has placed in a holding register moves into a shift register. The word is then shifted out most significant bit first, with one bit on each bit-clock edge. While no word is being shifted, the output-enable is held low, so the line is released (three-stated).

The host works with the block through write strobes. One strobe loads a data word. Another strobe requests a slot skip: the host writes nothing, and the next owned slot stays silent. A control strobe loads the enable, the interrupt enable, the slot-count field and the mask. Two status flags report "holding register empty" and "underrun". The interrupt request is active while the holding register is empty and both enables are set, so the host can refill the register once per owned slot. A new enable only takes effect at a frame sync. A dropped enable lets the current word finish before the line goes quiet.

The bit clock is provided as a one-cycle strobe (`bit_en`) in the system clock domain. The frame sync is sampled only on those strobes.

Top module: `tdm_net_tx`

## Requirements
- R1: The slot-count field `ctl_slot_div` = n (1..31) gives n+1 slots per frame, each WORD_W bit ticks long. After the last slot, counting goes back to slot 0 even when no frame sync is present.
- R2: A bit tick with `fsync` high is bit 0 of slot 0. Before the first such tick, and after setting the enable but before the next such tick, `sd_oe` stays low and the holding register is not consumed.
- R3: A `data_wr` pulse loads the holding register and clears `stat_empty`. At the tick that starts an active slot, the word moves to the shifter and `stat_empty` becomes 1. The word then appears on `sd_out` MSB first, one bit after each tick, with `sd_oe` high for exactly WORD_W ticks.
- R4: A `skip_wr` pulse clears `stat_empty` without supplying data. The next active slot keeps `sd_oe` low for the whole slot, sets `stat_empty`, and raises no underrun.
- R5: An active slot that starts while the holding register is empty keeps `sd_oe` low and sets `stat_underrun`. The flag stays set until an `err_clr` pulse. If both happen in the same cycle, setting the flag wins.
- R6: A slot is active only if bit i of the mask is 1, where i is the slot number. A masked slot keeps `sd_oe` low, leaves the holding register and `stat_empty` unchanged, and raises no underrun.
- R7: `irq` is high exactly when `stat_empty`, the interrupt enable and the transmit enable are all 1.
- R8: When the enable is cleared during a word, that word is still sent in full. From the next slot start, `sd_oe` stays low and nothing is consumed until a frame-sync tick finds the enable set, even if the enable is set again before that tick.
- R9: After reset, the enable and interrupt enable are 0, `stat_empty` is 1, `stat_underrun` is 0, and `sd_oe` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a bit-clock edge |
| fsync | input | 1 | Frame sync, sampled when `bit_en` is high |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | WORD_W | Word to transmit |
| skip_wr | input | 1 | Slot-skip write strobe (data ignored) |
| ctl_wr | input | 1 | Control write strobe |
| ctl_tx_en | input | 1 | Transmit enable |
| ctl_irq_en | input | 1 | Interrupt enable |
| ctl_slot_div | input | SLOT_W | Slots per frame minus one |
| ctl_slot_mask | input | MAX_SLOTS | Per-slot active mask |
| err_clr | input | 1 | Clears the underrun flag |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial output enable (low = three-stated) |
| irq | output | 1 | Transmit interrupt request |
| stat_empty | output | 1 | Holding register empty |
| stat_underrun | output | 1 | Sticky underrun flag |

## Verification
Every slot decision is registered on the clock edge of the `bit_en` tick that starts the slot. So `sd_oe`, the first data bit, `stat_empty`, `irq` and `stat_underrun` all change one edge after that tick, and each later bit changes one edge after its own tick. Host strobes update `stat_empty` and `stat_underrun` one edge after the strobe. The bench drives every strobe at a falling edge, holds it across exactly one rising edge, and reads the outputs at the next falling edge. Between ticks it leaves idle clock cycles, so that each host write falls clearly between two slot starts.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;

   typedef enum logic [1:0] {
      HOLD_EMPTY = 2'd0,
      HOLD_DATA  = 2'd1,
      HOLD_SKIP  = 2'd2
   } hold_e;

   typedef struct packed {
      logic tx_en;
      logic irq_en;
   } ctl_bits_t;

endpackage

// File: rtl/tdmtx_timing.sv
module tdmtx_timing #(
   parameter int WORD_W    = 16,
   parameter int MAX_SLOTS = 32,
   localparam int BIT_W    = $clog2(WORD_W),
   localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              fsync,
   input  logic [SLOT_W-1:0] slot_div,
   output logic              frame_start,
   output logic              slot_start,
   output logic [SLOT_W-1:0] slot_idx
);

   localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(WORD_W - 1);
   localparam logic [SLOT_W-1:0] MIN_LAST = SLOT_W'(1);

   logic              synced_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] last_slot;
   logic              wrap_start;

   always_comb begin
      last_slot   = (slot_div == '0) ? MIN_LAST : slot_div;
      frame_start = bit_en & fsync;
      wrap_start  = bit_en & synced_q & ~fsync & (bit_q == LAST_BIT);
      slot_start  = frame_start | wrap_start;
      if (frame_start || slot_q >= last_slot)
         slot_idx = '0;
      else
         slot_idx = slot_q + SLOT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q <= 1'b0;
         bit_q    <= '0;
         slot_q   <= '0;
      end else if (frame_start) begin
         synced_q <= 1'b1;
         bit_q    <= '0;
         slot_q   <= '0;
      end else if (wrap_start) begin
         bit_q    <= '0;
         slot_q   <= slot_idx;
      end else if (bit_en && synced_q) begin
         bit_q    <= bit_q + BIT_W'(1);
      end
   end

endmodule

// File: rtl/tdmtx_ctrl.sv
module tdmtx_ctrl
   import tdmtx_pkg::*;
#(
   parameter int MAX_SLOTS = 32,
   localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_wr,
   input  logic                 ctl_tx_en,
   input  logic                 ctl_irq_en,
   input  logic [SLOT_W-1:0]    ctl_slot_div,
   input  logic [MAX_SLOTS-1:0] ctl_slot_mask,
   input  logic                 frame_start,
   input  logic                 slot_start,
   input  logic [SLOT_W-1:0]    slot_idx,
   output ctl_bits_t            ctl_q,
   output logic [SLOT_W-1:0]    slot_div_q,
   output logic                 slot_active
);

   logic [MAX_SLOTS-1:0] mask_q;
   logic                 run_q;
   logic                 drop_q;
   logic                 run_next;

   always_comb begin
      if (frame_start)
         run_next = ctl_q.tx_en;
      else
         run_next = run_q & ctl_q.tx_en & ~drop_q;
      slot_active = slot_start & run_next & mask_q[slot_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         slot_div_q <= SLOT_W'(1);
         mask_q     <= '0;
      end else if (ctl_wr) begin
         ctl_q.tx_en  <= ctl_tx_en;
         ctl_q.irq_en <= ctl_irq_en;
         slot_div_q   <= ctl_slot_div;
         mask_q       <= ctl_slot_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         drop_q <= 1'b0;
      end else begin
         if (slot_start)
            run_q <= run_next;
         if (frame_start)
            drop_q <= 1'b0;
         else if (run_q && !ctl_q.tx_en)
            drop_q <= 1'b1;
      end
   end

endmodule

// File: rtl/tdmtx_hold.sv
module tdmtx_hold
   import tdmtx_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [WORD_W-1:0] data_in,
   input  logic              skip_wr,
   input  logic              err_clr,
   input  logic              slot_active,
   output logic              load,
   output logic [WORD_W-1:0] load_word,
   output logic              empty,
   output logic              underrun
);

   hold_e             hold_q;
   logic [WORD_W-1:0] word_q;
   logic              miss;

   always_comb begin
      load      = slot_active & (hold_q == HOLD_DATA);
      miss      = slot_active & (hold_q == HOLD_EMPTY);
      load_word = word_q;
      empty     = (hold_q == HOLD_EMPTY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= HOLD_EMPTY;
         word_q <= '0;
      end else if (data_wr) begin
         hold_q <= HOLD_DATA;
         word_q <= data_in;
      end else if (skip_wr) begin
         hold_q <= HOLD_SKIP;
      end else if (slot_active) begin
         hold_q <= HOLD_EMPTY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         underrun <= 1'b0;
      else if (miss)
         underrun <= 1'b1;
      else if (err_clr)
         underrun <= 1'b0;
   end

endmodule

// File: rtl/tdmtx_shifter.sv
module tdmtx_shifter #(
   parameter int WORD_W    = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              slot_start,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   output logic              sd_out,
   output logic              sd_oe
);

   logic [WORD_W-1:0] sreg_q;
   logic [WORD_W-1:0] sreg_shifted;
   logic              head_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb begin
            sreg_shifted = {sreg_q[WORD_W-2:0], 1'b0};
            head_bit     = sreg_q[WORD_W-1];
         end
      end else begin : g_lsb
         always_comb begin
            sreg_shifted = {1'b0, sreg_q[WORD_W-1:1]};
            head_bit     = sreg_q[0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         sd_oe  <= 1'b0;
      end else if (slot_start) begin
         sd_oe <= load;
         if (load)
            sreg_q <= load_word;
      end else if (bit_en) begin
         sreg_q <= sreg_shifted;
      end
   end

   assign sd_out = sd_oe & head_bit;

endmodule

// File: rtl/tdm_net_tx.sv
module tdm_net_tx
   import tdmtx_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int MAX_SLOTS = 32,
   parameter bit MSB_FIRST = 1'b1,
   localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_en,
   input  logic                 fsync,
   input  logic                 data_wr,
   input  logic [WORD_W-1:0]    data_in,
   input  logic                 skip_wr,
   input  logic                 ctl_wr,
   input  logic                 ctl_tx_en,
   input  logic                 ctl_irq_en,
   input  logic [SLOT_W-1:0]    ctl_slot_div,
   input  logic [MAX_SLOTS-1:0] ctl_slot_mask,
   input  logic                 err_clr,
   output logic                 sd_out,
   output logic                 sd_oe,
   output logic                 irq,
   output logic                 stat_empty,
   output logic                 stat_underrun
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $fatal(1, "tdm_net_tx: WORD_W must be at least 2");
      end
      if (MAX_SLOTS < 2 || (1 << SLOT_W) != MAX_SLOTS) begin : g_bad_slots
         $fatal(1, "tdm_net_tx: MAX_SLOTS must be a power of two, at least 2");
      end
   endgenerate

   logic              frame_start;
   logic              slot_start;
   logic [SLOT_W-1:0] slot_idx;
   logic [SLOT_W-1:0] slot_div_q;
   logic              slot_active;
   logic              load;
   logic [WORD_W-1:0] load_word;
   ctl_bits_t         ctl_q;

   tdmtx_timing #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS)) u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .fsync       (fsync),
      .slot_div    (slot_div_q),
      .frame_start (frame_start),
      .slot_start  (slot_start),
      .slot_idx    (slot_idx)
   );

   tdmtx_ctrl #(.MAX_SLOTS(MAX_SLOTS)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_wr        (ctl_wr),
      .ctl_tx_en     (ctl_tx_en),
      .ctl_irq_en    (ctl_irq_en),
      .ctl_slot_div  (ctl_slot_div),
      .ctl_slot_mask (ctl_slot_mask),
      .frame_start   (frame_start),
      .slot_start    (slot_start),
      .slot_idx      (slot_idx),
      .ctl_q         (ctl_q),
      .slot_div_q    (slot_div_q),
      .slot_active   (slot_active)
   );

   tdmtx_hold #(.WORD_W(WORD_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .data_wr     (data_wr),
      .data_in     (data_in),
      .skip_wr     (skip_wr),
      .err_clr     (err_clr),
      .slot_active (slot_active),
      .load        (load),
      .load_word   (load_word),
      .empty       (stat_empty),
      .underrun    (stat_underrun)
   );

   tdmtx_shifter #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .slot_start (slot_start),
      .load       (load),
      .load_word  (load_word),
      .sd_out     (sd_out),
      .sd_oe      (sd_oe)
   );

   assign irq = stat_empty & ctl_q.irq_en & ctl_q.tx_en;

endmodule

// File: rtl/tdm_net_tx_chk.sv
module tdm_net_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic data_wr,
   input logic skip_wr,
   input logic err_clr,
   input logic sd_oe,
   input logic irq,
   input logic stat_empty,
   input logic stat_underrun
);

   // R3
   oe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_en) |-> $stable(sd_oe));

   // R3
   wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !stat_empty);

   // R4
   skip_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_wr && !data_wr) |=> !stat_empty);

   // R5
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_underrun && !err_clr) |=> stat_underrun);

   // R5
   underrun_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_underrun) |-> $past(bit_en));

   // R7
   irq_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat_empty);

endmodule

bind tdm_net_tx tdm_net_tx_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bit_en        (bit_en),
   .data_wr       (data_wr),
   .skip_wr       (skip_wr),
   .err_clr       (err_clr),
   .sd_oe         (sd_oe),
   .irq           (irq),
   .stat_empty    (stat_empty),
   .stat_underrun (stat_underrun)
);

// File: tb/tdm_net_tx_bench.sv
module tdm_net_tx_bench;

   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        fsync = 1'b0;
   logic        data_wr = 1'b0;
   logic [W-1:0] data_in = '0;
   logic        skip_wr = 1'b0;
   logic        ctl_wr = 1'b0;
   logic        ctl_tx_en = 1'b0;
   logic        ctl_irq_en = 1'b0;
   logic [4:0]  ctl_slot_div = '0;
   logic [31:0] ctl_slot_mask = '0;
   logic        err_clr = 1'b0;
   logic        sd_out, sd_oe, irq, stat_empty, stat_underrun;

   int n_chk = 0;
   int n_err = 0;
   logic last_sd, last_oe;
   logic [4:0]  cur_div;
   logic [31:0] cur_mask;
   logic        cur_ie;

   always #5 clk = ~clk;

   tdm_net_tx u_tdm_net_tx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
      .data_wr(data_wr), .data_in(data_in), .skip_wr(skip_wr),
      .ctl_wr(ctl_wr), .ctl_tx_en(ctl_tx_en), .ctl_irq_en(ctl_irq_en),
      .ctl_slot_div(ctl_slot_div), .ctl_slot_mask(ctl_slot_mask),
      .err_clr(err_clr), .sd_out(sd_out), .sd_oe(sd_oe), .irq(irq),
      .stat_empty(stat_empty), .stat_underrun(stat_underrun)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic host_ctl(input bit en, input bit ie, input logic [4:0] div,
                           input logic [31:0] mask);
      cur_div = div; cur_mask = mask; cur_ie = ie;
      @(negedge clk);
      ctl_wr = 1'b1; ctl_tx_en = en; ctl_irq_en = ie;
      ctl_slot_div = div; ctl_slot_mask = mask;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic host_data(input logic [W-1:0] w);
      @(negedge clk);
      data_wr = 1'b1; data_in = w;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic host_skip();
      @(negedge clk);
      skip_wr = 1'b1; data_in = 16'hFFFF;
      @(negedge clk);
      skip_wr = 1'b0;
   endtask

   task automatic host_clr();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic tick(input bit fs);
      @(negedge clk);
      bit_en = 1'b1; fsync = fs;
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0;
      last_sd = sd_out; last_oe = sd_oe;
      repeat (2) @(negedge clk);
   endtask

   task automatic slot(input bit fs, output logic [W-1:0] w, output int oe_n,
                       output logic emp1, output logic irq1);
      w = '0; oe_n = 0; emp1 = 1'b0; irq1 = 1'b0;
      for (int k = 0; k < W; k++) begin
         tick(fs && (k == 0));
         if (k == 0) begin emp1 = stat_empty; irq1 = irq; end
         w = {w[W-2:0], last_sd};
         oe_n += int'(last_oe);
      end
   endtask

   task automatic t_reset();
      do_reset();
      check(sd_oe == 1'b0, "R9", "oe after reset", sd_oe, 0);
      check(stat_empty == 1'b1, "R9", "empty after reset", stat_empty, 1);
      check(stat_underrun == 1'b0, "R9", "underrun after reset", stat_underrun, 0);
      check(irq == 1'b0, "R9", "irq after reset", irq, 0);
   endtask

   task automatic t_wait_sync();
      logic [W-1:0] w; int oe_n; logic e1, i1; int seen;
      do_reset();
      host_ctl(1'b1, 1'b0, 5'd3, 32'hF);
      host_data(16'h5A3C);
      seen = 0;
      for (int k = 0; k < 40; k++) begin
         tick(1'b0);
         seen += int'(last_oe);
      end
      check(seen == 0, "R2", "oe before frame sync", seen, 0);
      check(stat_empty == 1'b0, "R2", "word held before sync", stat_empty, 0);
      slot(1'b1, w, oe_n, e1, i1);
      check(w == 16'h5A3C, "R2", "word sent at sync", w, 16'h5A3C);
      check(oe_n == W, "R2", "oe ticks at sync slot", oe_n, W);
   endtask

   task automatic t_stream();
      logic [W-1:0] w; int oe_n; logic e1, i1;
      do_reset();
      host_ctl(1'b1, 1'b1, 5'd3, 32'hF);
      host_data(16'hA5C3);
      check(stat_empty == 1'b0, "R3", "write clears empty", stat_empty, 0);
      check(irq == 1'b0, "R7", "irq low while full", irq, 0);
      slot(1'b1, w, oe_n, e1, i1);
      check(w == 16'hA5C3, "R3", "slot0 word MSB first", w, 16'hA5C3);
      check(oe_n == W, "R3", "slot0 oe ticks", oe_n, W);
      check(e1 == 1'b1, "R3", "empty at slot start", e1, 1);
      check(i1 == 1'b1, "R7", "irq at slot start", i1, 1);
      host_data(16'h3C71);
      slot(1'b0, w, oe_n, e1, i1);
      check(w == 16'h3C71, "R3", "slot1 word", w, 16'h3C71);
      host_skip();
      check(stat_empty == 1'b0, "R4", "skip clears empty", stat_empty, 0);
      slot(1'b0, w, oe_n, e1, i1);
      check(oe_n == 0, "R4", "skipped slot oe", oe_n, 0);
      check(e1 == 1'b1, "R4", "empty after skip slot", e1, 1);
      check(stat_underrun == 1'b0, "R4", "no underrun on skip", stat_underrun, 0);
      slot(1'b0, w, oe_n, e1, i1);
      check(oe_n == 0, "R5", "underrun slot oe", oe_n, 0);
      check(stat_underrun == 1'b1, "R5", "underrun set", stat_underrun, 1);
      repeat (3) @(negedge clk);
      check(stat_underrun == 1'b1, "R5", "underrun sticky", stat_underrun, 1);
      host_clr();
      check(stat_underrun == 1'b0, "R5", "underrun cleared", stat_underrun, 0);
      host_ctl(1'b1, 1'b0, 5'd3, 32'hF);
      check(irq == 1'b0, "R7", "irq with ie low", irq, 0);
   endtask

   task automatic t_mask();
      logic [W-1:0] w; int oe_n; logic e1, i1;
      do_reset();
      host_ctl(1'b1, 1'b0, 5'd3, 32'h5);
      host_data(16'h1234);
      slot(1'b1, w, oe_n, e1, i1);
      check(w == 16'h1234, "R6", "active slot0", w, 16'h1234);
      host_data(16'hBEEF);
      slot(1'b0, w, oe_n, e1, i1);
      check(oe_n == 0, "R6", "masked slot1 oe", oe_n, 0);
      check(stat_empty == 1'b0, "R6", "masked slot keeps word", stat_empty, 0);
      slot(1'b0, w, oe_n, e1, i1);
      check(w == 16'hBEEF, "R6", "active slot2", w, 16'hBEEF);
      slot(1'b0, w, oe_n, e1, i1);
      check(stat_underrun == 1'b0, "R6", "masked slot3 no underrun", stat_underrun, 0);
      slot(1'b0, w, oe_n, e1, i1);
      check(stat_underrun == 1'b1, "R1", "wrapped slot0 is active", stat_underrun, 1);
   endtask

   task automatic t_slot_count();
      logic [W-1:0] w; int oe_n; logic e1, i1; int seen;
      do_reset();
      host_ctl(1'b1, 1'b0, 5'd1, 32'h1);
      host_data(16'hC001);
      slot(1'b1, w, oe_n, e1, i1);
      check(w == 16'hC001, "R1", "two-slot frame slot0", w, 16'hC001);
      host_data(16'h0FF0);
      slot(1'b0, w, oe_n, e1, i1);
      check(oe_n == 0, "R1", "two-slot frame slot1", oe_n, 0);
      slot(1'b0, w, oe_n, e1, i1);
      check(w == 16'h0FF0, "R1", "two-slot wrap", w, 16'h0FF0);
      do_reset();
      host_ctl(1'b1, 1'b0, 5'd31, 32'h8000_0000);
      host_data(16'h9E37);
      seen = 0;
      slot(1'b1, w, oe_n, e1, i1);
      seen += oe_n;
      for (int s = 1; s < 31; s++) begin
         slot(1'b0, w, oe_n, e1, i1);
         seen += oe_n;
      end
      check(seen == 0 && stat_empty == 1'b0, "R1", "slots 0..30 silent", seen, 0);
      slot(1'b0, w, oe_n, e1, i1);
      check(w == 16'h9E37 && oe_n == W, "R1", "slot31 of 32", w, 16'h9E37);
   endtask

   task automatic t_disable();
      logic [W-1:0] w; int oe_n; logic e1, i1;
      do_reset();
      host_ctl(1'b1, 1'b0, 5'd3, 32'hF);
      host_data(16'hD00D);
      w = '0; oe_n = 0;
      for (int k = 0; k < W; k++) begin
         tick(k == 0);
         w = {w[W-2:0], last_sd};
         oe_n += int'(last_oe);
         if (k == 7) host_ctl(1'b0, 1'b0, 5'd3, 32'hF);
      end
      check(w == 16'hD00D && oe_n == W, "R8", "word finishes after disable", w, 16'hD00D);
      host_data(16'h7711);
      host_ctl(1'b1, 1'b0, 5'd3, 32'hF);
      slot(1'b0, w, oe_n, e1, i1);
      check(oe_n == 0, "R8", "re-enabled mid-frame stays off", oe_n, 0);
      check(stat_empty == 1'b0, "R8", "word not consumed", stat_empty, 0);
      slot(1'b0, w, oe_n, e1, i1);
      slot(1'b0, w, oe_n, e1, i1);
      check(stat_underrun == 1'b0, "R8", "no underrun while off", stat_underrun, 0);
      slot(1'b1, w, oe_n, e1, i1);
      check(w == 16'h7711 && oe_n == W, "R8", "restart at frame sync", w, 16'h7711);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_wait_sync();
      t_stream();
      t_mask();
      t_slot_count();
      t_disable();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule